// File: doc/BRIEF.md
# Strobe-Qualified Video Line Capture

This block takes a 16-bit pixel stream that carries luma and colour-difference samples side by side in straight binary. The stream runs on a clock at twice the pixel rate. A qualifier strobe marks the cycles that carry a real pixel, which in normal use is every other cycle. A horizontal reference input marks line timing. It may be a short pulse or a gate, and a polarity input picks whether its rising or falling transition counts. After that transition the block skips a programmable number of qualified pixels. It then hands out a programmable number of active pixels, each tagged with a valid flag, a line-start marker on the first one, and an index within the line.

The sequencer is a four-state machine. IDLE is the state after reset, with no line seen yet. SKIP counts qualified pixels up to the start offset. ACTIVE emits pixels until the active count is reached. DONE waits for the next reference edge.

The named transitions are:
- **line_start**: from any state to SKIP, on a reference edge.
- **offset_hit**: SKIP to ACTIVE, on the qualified pixel whose number equals the offset.
- **short_line**: SKIP straight to DONE, when the active count is 0 or 1.
- **count_end**: ACTIVE to DONE, after the last active pixel.

Pixel values are never altered, so codes outside the nominal video range pass through as they are.

Top module: `vid_line_capture`

## Requirements
- R1: After reset `out_valid`, `out_sol`, `out_index` and `out_data` are 0, and no pixel is emitted until a reference edge has been seen.
- R2: With `href_pol`=1 a change of `href` from 0 to 1 between two successive cycles is the line edge. With `href_pol`=0 a change from 1 to 0 is the line edge. The opposite transition has no effect on the line in progress.
- R3: Qualified pixels after the edge are numbered from 0, and a qualified pixel in the edge cycle itself is number 0. Number `start_offset` is the first active pixel.
- R4: A cycle with `pix_qual`=0 never advances the offset or index counters and never yields `out_valid`=1.
- R5: `out_index` is 0 for the first active pixel of a line and rises by exactly one per emitted qualified pixel.
- R6: `out_sol` is 1 only together with `out_valid`=1 and `out_index`=0, on the first active pixel of a line.
- R7: Exactly `active_count` pixels are emitted per line, and none when it is 0. After the last one `out_valid` stays 0 until the next line edge.
- R8: `out_data` equals the 16-bit input of the qualified cycle unchanged, including values above 235 or below 16 in either byte.
- R9: A line edge that arrives while a line is still in SKIP or ACTIVE restarts the offset count in that same cycle. The old line emits no further pixels.
- R10: Each emitted pixel appears on the outputs exactly one clock cycle after the cycle in which it was presented with `pix_qual`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate line-locked clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_data | input | 16 | Luma and colour-difference sample pair |
| pix_qual | input | 1 | Qualifier strobe; 1 marks a real pixel |
| href | input | 1 | Horizontal reference, pulse or gate |
| href_pol | input | 1 | 1: rising edge starts a line, 0: falling edge |
| start_offset | input | 12 | Qualified pixels to skip after the edge |
| active_count | input | 12 | Active pixels per line |
| out_data | output | 16 | Captured pixel |
| out_valid | output | 1 | Captured pixel is valid this cycle |
| out_sol | output | 1 | First active pixel of the line |
| out_index | output | 12 | Index of the pixel within the active region |

## Verification
A reference edge and a qualified pixel can fall in the same cycle. In that case the edge must both restart the count and let that pixel count as number 0, even while the old line is still active. The bench provokes this on purpose: lines begin with the strobe high in the edge cycle, and a new edge is placed directly after a truncated line. A scoreboard holds the expected pixel, index, marker and arrival cycle for every emitted pixel. Any pixel that is missing, extra or shifted shows up as a mismatch in data, index or cycle.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SKIP   = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_DONE   = 2'd3
    } vlc_state_e;

endpackage

// File: rtl/vlc_href_edge.sv
module vlc_href_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic href,
    input  logic href_pol,
    output logic line_edge
);
    logic act_now;
    logic act_q;

    assign act_now = href_pol ? href : ~href;

    // Reset to the active level so a reference held active through reset
    // does not produce a spurious edge.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b1;
        else        act_q <= act_now;
    end

    assign line_edge = act_now & ~act_q;

endmodule

// File: rtl/vlc_line_fsm.sv
module vlc_line_fsm
    import vlc_pkg::*;
#(
    parameter int OFFS_W = 12,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_edge,
    input  logic              qual,
    input  logic [OFFS_W-1:0] start_offset,
    input  logic [CNT_W-1:0]  active_count,
    output logic              emit,
    output logic              emit_first,
    output logic [CNT_W-1:0]  emit_idx
);
    localparam logic [CNT_W-1:0] IDX_ONE = CNT_W'(1);

    vlc_state_e        st_q, st_d, cur_st;
    logic [OFFS_W-1:0] skip_q, skip_d, cur_skip;
    logic [CNT_W-1:0]  idx_q, idx_d, cur_idx;
    logic [CNT_W:0]    idx_plus;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            skip_q <= '0;
            idx_q  <= '0;
        end else begin
            st_q   <= st_d;
            skip_q <= skip_d;
            idx_q  <= idx_d;
        end
    end

    // An edge overrides the registered state in its own cycle (line_start)
    always_comb begin
        cur_st   = line_edge ? ST_SKIP : st_q;
        cur_skip = line_edge ? '0      : skip_q;
        cur_idx  = line_edge ? '0      : idx_q;
    end

    assign idx_plus = {1'b0, cur_idx} + {{CNT_W{1'b0}}, 1'b1};

    // Next-state and emit process
    always_comb begin
        st_d       = cur_st;
        skip_d     = cur_skip;
        idx_d      = cur_idx;
        emit       = 1'b0;
        emit_first = 1'b0;
        emit_idx   = cur_idx;
        if (qual) begin
            unique case (cur_st)
                ST_IDLE: begin
                    st_d = ST_IDLE;
                end
                ST_SKIP: begin
                    if (cur_skip == start_offset) begin
                        if (active_count == '0) begin
                            st_d = ST_DONE;                  // short_line
                        end else begin
                            emit       = 1'b1;
                            emit_first = 1'b1;
                            emit_idx   = '0;
                            if (active_count == IDX_ONE) begin
                                st_d = ST_DONE;              // short_line
                            end else begin
                                st_d  = ST_ACTIVE;           // offset_hit
                                idx_d = IDX_ONE;
                            end
                        end
                    end else begin
                        skip_d = cur_skip + 1'b1;
                    end
                end
                ST_ACTIVE: begin
                    emit     = 1'b1;
                    emit_idx = cur_idx;
                    if (idx_plus == {1'b0, active_count}) begin
                        st_d = ST_DONE;                      // count_end
                    end else begin
                        idx_d = idx_plus[CNT_W-1:0];
                    end
                end
                ST_DONE: begin
                    st_d = ST_DONE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // R9: an edge in an unqualified cycle leaves SKIP armed at count zero
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_edge && !qual) |=> (st_q == ST_SKIP && skip_q == '0));

    // R4: without strobe or edge the counters and state hold
    p_hold_no_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_edge && !qual) |=> ($stable(st_q) && $stable(skip_q) && $stable(idx_q)));

    // R1: nothing leaves IDLE except an edge
    p_idle_needs_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !line_edge) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/vlc_out_stage.sv
module vlc_out_stage #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit,
    input  logic              emit_first,
    input  logic [CNT_W-1:0]  emit_idx,
    input  logic [DATA_W-1:0] pix_data,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_sol,
    output logic [CNT_W-1:0]  out_index
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_data  <= '0;
            out_index <= '0;
        end else begin
            out_valid <= emit;
            out_sol   <= emit & emit_first;
            if (emit) begin
                out_data  <= pix_data;
                out_index <= emit_idx;
            end
        end
    end

endmodule

// File: rtl/vid_line_capture.sv
module vid_line_capture #(
    parameter int DATA_W = 16,
    parameter int OFFS_W = 12,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              pix_qual,
    input  logic              href,
    input  logic              href_pol,
    input  logic [OFFS_W-1:0] start_offset,
    input  logic [CNT_W-1:0]  active_count,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_sol,
    output logic [CNT_W-1:0]  out_index
);
    logic             line_edge;
    logic             emit;
    logic             emit_first;
    logic [CNT_W-1:0] emit_idx;

    vlc_href_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .href      (href),
        .href_pol  (href_pol),
        .line_edge (line_edge)
    );

    vlc_line_fsm #(.OFFS_W(OFFS_W), .CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_edge    (line_edge),
        .qual         (pix_qual),
        .start_offset (start_offset),
        .active_count (active_count),
        .emit         (emit),
        .emit_first   (emit_first),
        .emit_idx     (emit_idx)
    );

    vlc_out_stage #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .emit       (emit),
        .emit_first (emit_first),
        .emit_idx   (emit_idx),
        .pix_data   (pix_data),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_sol    (out_sol),
        .out_index  (out_index)
    );

    p_valid_needs_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pix_qual));

    p_sol_index_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> (out_valid && out_index == '0));

    p_data_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data == $past(pix_data)));

endmodule

// File: tb/vid_line_capture_test.sv
module vid_line_capture_test;

    typedef struct {
        logic [15:0] data;
        logic [11:0] idx;
        logic        sol;
        int          cyc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pix_data = '0;
    logic        pix_qual = 1'b0;
    logic        href = 1'b0;
    logic        href_pol = 1'b1;
    logic [11:0] start_offset = '0;
    logic [11:0] active_count = '0;
    logic [15:0] out_data;
    logic        out_valid;
    logic        out_sol;
    logic [11:0] out_index;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   cyc     = 0;
    bit   done    = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    vid_line_capture uut (
        .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .pix_qual(pix_qual),
        .href(href), .href_pol(href_pol), .start_offset(start_offset),
        .active_count(active_count), .out_data(out_data), .out_valid(out_valid),
        .out_sol(out_sol), .out_index(out_index)
    );

    // Monitor: pop and compare every emitted pixel (R3 R5 R6 R7 R8 R10)
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            n_tests++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R7 unexpected pixel data=%h idx=%0d cyc=%0d, expected none",
                         out_data, out_index, cyc);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (out_data !== e.data || out_index !== e.idx || out_sol !== e.sol || cyc != e.cyc) begin
                    n_fail++;
                    $display("FAIL R3/R5/R6/R8/R10 got data=%h idx=%0d sol=%0b cyc=%0d, expected data=%h idx=%0d sol=%0b cyc=%0d",
                             out_data, out_index, out_sol, cyc, e.data, e.idx, e.sol, e.cyc);
                end
            end
        end
    end

    function automatic logic [15:0] pdat(logic [15:0] seed, int k);
        return seed ^ 16'(k * 16'h0B13);
    endfunction

    task automatic gap(int n);
        for (int c = 0; c < n; c++) begin
            @(posedge clk); #1;
            href     = href_pol ? 1'b0 : 1'b1;
            pix_qual = c[0];
            pix_data = 16'hA5A5 ^ 16'(c);
        end
    endtask

    task automatic run_line(bit gate, bit qfirst, int off, int cnt, int nq, logic [15:0] seed);
        for (int c = 0; c < 2 * nq; c++) begin
            bit q;
            bit h_act;
            int k;
            q     = qfirst ? (c % 2 == 0) : (c % 2 == 1);
            k     = c / 2;
            h_act = gate ? 1'b1 : (c < 2);
            @(posedge clk); #1;
            if (c == 0) begin
                start_offset = 12'(off);
                active_count = 12'(cnt);
            end
            href     = href_pol ? h_act : !h_act;
            pix_qual = q;
            pix_data = q ? pdat(seed, k) : (16'hDEAD ^ 16'(c));
            if (q && k >= off && k < off + cnt) begin
                exp_t e;
                e.data = pix_data;
                e.idx  = 12'(k - off);
                e.sol  = (k == off);
                e.cyc  = cyc + 1;
                sb.push_back(e);
            end
        end
    endtask

    task automatic check_quiet(string req, int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            n_tests++;
            if (out_valid !== 1'b0) begin
                n_fail++;
                $display("FAIL %s out_valid=%b expected 0", req, out_valid);
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired, got hang expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        n_tests++;
        if (out_valid !== 0 || out_sol !== 0 || out_index !== 0 || out_data !== 0) begin
            n_fail++;
            $display("FAIL R1 outputs v=%b s=%b i=%0d d=%h expected all 0",
                     out_valid, out_sol, out_index, out_data);
        end
        // R1/R4: strobes without any edge give nothing
        gap(12);
        check_quiet("R1", 2);

        // R2 R3 rising pulse, qualified edge cycle, offset 3
        run_line(1'b0, 1'b1, 3, 5, 10, 16'hEB10);
        gap(6);
        // R3 unqualified edge cycle, gate, offset 0
        run_line(1'b1, 1'b0, 0, 4, 6, 16'hFF00);
        gap(6);
        // R7 single pixel
        run_line(1'b0, 1'b1, 0, 1, 4, 16'h000F);
        gap(4);
        // R7 count zero gives nothing
        run_line(1'b0, 1'b1, 2, 0, 6, 16'h1234);
        gap(4);
        check_quiet("R7", 2);
        // R9 truncated line then immediate new edge
        run_line(1'b0, 1'b1, 2, 10, 6, 16'h0005);
        run_line(1'b0, 1'b1, 1, 3, 5, 16'hF0F0);
        gap(6);
        // R9 restart with unqualified edge cycle
        run_line(1'b0, 1'b1, 1, 20, 5, 16'h3C3C);
        run_line(1'b0, 1'b0, 2, 2, 5, 16'hC3C3);
        gap(6);

        // R2 falling polarity: switch pol and idle level together
        @(posedge clk); #1;
        href_pol = 1'b0; href = 1'b1; pix_qual = 1'b0;
        gap(4);
        run_line(1'b0, 1'b1, 2, 6, 9, 16'hEBEB);
        gap(6);
        run_line(1'b1, 1'b0, 1, 3, 5, 16'h0010);
        gap(6);
        // R3 R5 long offset and run
        run_line(1'b0, 1'b1, 40, 50, 95, 16'h80F1);
        gap(10);
        check_quiet("R7", 2);

        n_tests++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R7 missing pixels got %0d left expected 0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule